// File: doc/BRIEF.md
# USB Endpoint Stall and Status Manager

This block holds the status of sixteen device-side USB endpoints. Endpoint 0 is the control OUT endpoint, endpoint 1 is the control IN endpoint, and endpoints 2 to 15 are general endpoints. By default odd endpoints are IN and even endpoints are OUT. A microprocessor sends one-byte commands that stall or unstall an endpoint. The serial interface engine reports four kinds of event as single-cycle pulses, each with an endpoint index: SETUP token seen, setup data written, buffer filled, and buffer drained.

Each endpoint keeps the following state: a stall bit, a data toggle, two full flags for its double buffer, fill and drain pointers, and three setup flags. The three setup flags are write in progress, setup held and setup overwritten. The CPU can read one status byte per endpoint. The byte comes back one cycle after the request.

All inputs are plain strobes and are accepted every cycle. There is no back-pressure on the command port, the event pulses or the read port. The caller must keep the data of a strobe valid in the cycle the strobe is high.

Top module: `usb_ep_status_mgr`

## Requirements
- R1: After reset every status bit of every endpoint reads 0.
- R2: A read request sets `rd_valid` for exactly the next cycle. The returned byte is the endpoint's state before that cycle's updates, laid out as follows:
  - bit 7: stalled
  - bit 6: secondary buffer full
  - bit 5: primary buffer full
  - bit 4: next data PID (1 = DATA1)
  - bit 3: setup overwritten
  - bit 2: setup held
  - bit 1: CPU buffer select (1 = secondary)
  - bit 0: always 0
- R3: Command 0x40+n sets the stall bit of endpoint n. All other status bits of that endpoint are left unchanged.
- R4: Command 0x80+n clears the stall bit of endpoint n and re-initializes the endpoint. Re-initializing clears both full flags, forces DATA0 and returns both pointers to primary. This happens even if the endpoint was not stalled. A fill or drain event in the same cycle as the re-initialization is discarded.
- R5: Command bytes outside 0x40–0x4F and 0x80–0x8F change no state.
- R6: A SETUP token on endpoint 0 or 1 clears that endpoint's stall bit. If the endpoint was stalled, the token also re-initializes it. A command in the same cycle is applied after the token, so a stall command issued with the token leaves the endpoint stalled. SETUP-token and setup-written events on endpoints 2–15 are ignored.
- R7: A SETUP token starts a setup write and clears bit 2. If bit 2 was set, or a setup write was still in progress, the token also sets bit 3. A setup-written event completes the write and sets bit 2. A drain event clears bit 2.
- R8: A read that finds no setup write in progress clears bit 3 after the byte is captured. While a setup write is in progress, bit 3 survives reads.
- R9: A fill event sets the full flag of the buffer under the fill pointer and moves the fill pointer to the other buffer. A drain event clears the full flag under the drain pointer and moves the drain pointer. A fill into a full buffer and a drain from an empty buffer are ignored. Bit 1 shows the drain pointer on OUT endpoints and the fill pointer on IN endpoints.
- R10: The data PID toggles on each USB-side transfer: an accepted fill on an OUT endpoint, or an accepted drain on an IN endpoint.
- R11: A stalled endpoint ignores fill and drain events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| setup_tok | input | 1 | SETUP token received pulse |
| setup_tok_ep | input | 4 | Endpoint of the SETUP token |
| setup_wr_done | input | 1 | Setup data written pulse |
| setup_wr_ep | input | 4 | Endpoint of the setup write |
| buf_fill | input | 1 | Buffer filled pulse |
| buf_fill_ep | input | 4 | Endpoint of the fill |
| buf_drain | input | 1 | Buffer drained pulse |
| buf_drain_ep | input | 4 | Endpoint of the drain |
| rd_req | input | 1 | Status read request |
| rd_ep | input | 4 | Endpoint to read |
| rd_valid | output | 1 | Status byte valid |
| rd_data | output | 8 | Status byte |

## Verification
The bench issues a SETUP token and a re-stall command to the same endpoint in the same cycle. A design that applied the command first would report the endpoint unstalled. The bench reads the overwrite bit both during and after a setup write. A design that cleared the bit on every read would lose it during the write, and one that cleared it before capture would return 0. The bench fills a full double buffer and drains both a stalled and an empty one. Wrong pointer or guard logic would show as a wrong full flag, CPU select or toggle. The bench unstalls an endpoint that is not stalled, and sends command bytes just outside the two valid ranges. A design that skipped re-initialization, or decoded only part of the byte, would show a stale toggle or altered state.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

  typedef struct packed {
    logic       stall;
    logic [1:0] full;   // [0] primary, [1] secondary
    logic       pid;
    logic       ovw;
    logic       hold;
    logic       busy;
    logic       fptr;
    logic       dptr;
  } ep_state_t;

  localparam logic [3:0] OP_STALL   = 4'h4;
  localparam logic [3:0] OP_UNSTALL = 4'h8;

  function automatic logic [7:0] pack_status(input ep_state_t s, input logic cpu_sel);
    return {s.stall, s.full[1], s.full[0], s.pid, s.ovw, s.hold, cpu_sel, 1'b0};
  endfunction

endpackage

// File: rtl/ep_onehot.sv
module ep_onehot #(
  parameter int N   = 16,
  parameter int IDW = 4
) (
  input  logic           valid,
  input  logic [IDW-1:0] idx,
  output logic [N-1:0]   hot
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign hot[g] = valid && (idx == IDW'(g));
  end
endmodule

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_status_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EPW   = $clog2(NUM_EP)
) (
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic [NUM_EP-1:0] stall_hot,
  output logic [NUM_EP-1:0] unstall_hot
);
  logic in_range;
  logic is_stall;
  logic is_unstall;

  assign in_range   = ({28'd0, cmd_code[3:0]} < NUM_EP);
  assign is_stall   = cmd_valid && in_range && (cmd_code[7:4] == OP_STALL);
  assign is_unstall = cmd_valid && in_range && (cmd_code[7:4] == OP_UNSTALL);

  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_stall_hot (
    .valid(is_stall), .idx(cmd_code[EPW-1:0]), .hot(stall_hot)
  );
  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_unstall_hot (
    .valid(is_unstall), .idx(cmd_code[EPW-1:0]), .hot(unstall_hot)
  );
endmodule

// File: rtl/ep_slot.sv
module ep_slot
  import ep_status_pkg::*;
#(
  parameter bit IS_CTRL = 1'b0,
  parameter bit IS_IN   = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok,
  input  logic       wr_done,
  input  logic       fill,
  input  logic       drain,
  input  logic       stall_cmd,
  input  logic       unstall_cmd,
  input  logic       rd_clr,
  output logic [7:0] status
);
  ep_state_t st, nx;
  logic      reinit;

  always_comb begin
    nx     = st;
    reinit = 1'b0;
    // clear-on-read uses the captured state
    if (rd_clr && !st.busy) nx.ovw = 1'b0;
    // SETUP token first
    if (IS_CTRL && tok) begin
      if (nx.stall) reinit = 1'b1;
      nx.stall = 1'b0;
      if (nx.hold || nx.busy) nx.ovw = 1'b1;
      nx.busy = 1'b1;
      nx.hold = 1'b0;
    end
    // command after token
    if (stall_cmd) nx.stall = 1'b1;
    if (unstall_cmd) begin
      nx.stall = 1'b0;
      reinit   = 1'b1;
    end
    if (reinit) begin
      nx.full = 2'b00;
      nx.pid  = 1'b0;
      nx.fptr = 1'b0;
      nx.dptr = 1'b0;
    end
    if (IS_CTRL && wr_done && nx.busy) begin
      nx.busy = 1'b0;
      nx.hold = 1'b1;
    end
    if (drain) nx.hold = 1'b0;
    // buffer traffic
    if (!reinit && !nx.stall) begin
      if (fill && !nx.full[nx.fptr]) begin
        nx.full[nx.fptr] = 1'b1;
        nx.fptr          = ~nx.fptr;
        if (!IS_IN) nx.pid = ~nx.pid;
      end
      if (drain && nx.full[nx.dptr]) begin
        nx.full[nx.dptr] = 1'b0;
        nx.dptr          = ~nx.dptr;
        if (IS_IN) nx.pid = ~nx.pid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= nx;
  end

  assign status = pack_status(st, IS_IN ? st.fptr : st.dptr);
endmodule

// File: rtl/ep_status_rd.sv
module ep_status_rd #(
  parameter int NUM_EP = 16,
  localparam int EPW   = $clog2(NUM_EP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EP-1:0][7:0] stat_arr,
  input  logic                  rd_req,
  input  logic [EPW-1:0]        rd_ep,
  output logic                  rd_valid,
  output logic [7:0]            rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= stat_arr[rd_ep];
    end
  end
endmodule

// File: rtl/usb_ep_status_mgr.sv
module usb_ep_status_mgr #(
  parameter int              NUM_EP    = 16,
  parameter logic [NUM_EP-1:0] CTRL_MASK = 16'h0003,
  parameter logic [NUM_EP-1:0] IN_MASK   = 16'hAAAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       setup_tok,
  input  logic [3:0] setup_tok_ep,
  input  logic       setup_wr_done,
  input  logic [3:0] setup_wr_ep,
  input  logic       buf_fill,
  input  logic [3:0] buf_fill_ep,
  input  logic       buf_drain,
  input  logic [3:0] buf_drain_ep,
  input  logic       rd_req,
  input  logic [3:0] rd_ep,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  localparam int EPW = $clog2(NUM_EP);

  logic [NUM_EP-1:0]      tok_hot, wr_hot, fill_hot, drain_hot, rd_hot;
  logic [NUM_EP-1:0]      stall_hot, unstall_hot;
  logic [NUM_EP-1:0][7:0] stat_arr;

  ep_cmd_decode #(.NUM_EP(NUM_EP)) u_dec (
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .stall_hot(stall_hot), .unstall_hot(unstall_hot)
  );

  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_tok_hot (
    .valid(setup_tok), .idx(setup_tok_ep[EPW-1:0]), .hot(tok_hot));
  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_wr_hot (
    .valid(setup_wr_done), .idx(setup_wr_ep[EPW-1:0]), .hot(wr_hot));
  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_fill_hot (
    .valid(buf_fill), .idx(buf_fill_ep[EPW-1:0]), .hot(fill_hot));
  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_drain_hot (
    .valid(buf_drain), .idx(buf_drain_ep[EPW-1:0]), .hot(drain_hot));
  ep_onehot #(.N(NUM_EP), .IDW(EPW)) u_rd_hot (
    .valid(rd_req), .idx(rd_ep[EPW-1:0]), .hot(rd_hot));

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    ep_slot #(.IS_CTRL(CTRL_MASK[g]), .IS_IN(IN_MASK[g])) u_slot (
      .clk(clk), .rst_n(rst_n),
      .tok(tok_hot[g]), .wr_done(wr_hot[g]),
      .fill(fill_hot[g]), .drain(drain_hot[g]),
      .stall_cmd(stall_hot[g]), .unstall_cmd(unstall_hot[g]),
      .rd_clr(rd_hot[g]), .status(stat_arr[g])
    );
  end

  ep_status_rd #(.NUM_EP(NUM_EP)) u_rd (
    .clk(clk), .rst_n(rst_n), .stat_arr(stat_arr),
    .rd_req(rd_req), .rd_ep(rd_ep[EPW-1:0]),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/ep_status_chk.sv
module ep_status_chk #(
  parameter int NUM_EP = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [7:0]             cmd_code,
  input logic                   setup_tok,
  input logic [3:0]             setup_tok_ep,
  input logic                   setup_wr_done,
  input logic                   buf_fill,
  input logic                   buf_drain,
  input logic                   rd_req,
  input logic                   rd_valid,
  input logic [NUM_EP-1:0][7:0] stat_arr
);
  logic is_stall, is_unstall;
  assign is_stall   = cmd_valid && (cmd_code[7:4] == 4'h4);
  assign is_unstall = cmd_valid && (cmd_code[7:4] == 4'h8);

  a_r3_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    is_stall |=> stat_arr[$past(cmd_code[3:0])][7]);

  a_r4_unstall_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    is_unstall |=> (stat_arr[$past(cmd_code[3:0])][7:4] == 4'h0)
                   && !stat_arr[$past(cmd_code[3:0])][1]);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  a_r5_ignored_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_stall && !is_unstall && !setup_tok && !setup_wr_done
     && !buf_fill && !buf_drain && !rd_req) |=> $stable(stat_arr));

  a_r6_setup_unstalls: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_tok && setup_tok_ep == 4'd0 && !(is_stall && cmd_code[3:0] == 4'd0))
    |=> !stat_arr[0][7]);

  a_r7_ovw_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_arr[0][3]) |-> $past(setup_tok && setup_tok_ep == 4'd0));
endmodule

bind usb_ep_status_mgr ep_status_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .setup_tok(setup_tok), .setup_tok_ep(setup_tok_ep),
  .setup_wr_done(setup_wr_done), .buf_fill(buf_fill), .buf_drain(buf_drain),
  .rd_req(rd_req), .rd_valid(rd_valid), .stat_arr(stat_arr)
);

// File: tb/tb_usb_ep_status_mgr.sv
module tb_usb_ep_status_mgr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       setup_tok = 1'b0;
  logic [3:0] setup_tok_ep = 4'd0;
  logic       setup_wr_done = 1'b0;
  logic [3:0] setup_wr_ep = 4'd0;
  logic       buf_fill = 1'b0;
  logic [3:0] buf_fill_ep = 4'd0;
  logic       buf_drain = 1'b0;
  logic [3:0] buf_drain_ep = 4'd0;
  logic       rd_req = 1'b0;
  logic [3:0] rd_ep = 4'd0;
  logic       rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_status_mgr dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .setup_tok(setup_tok), .setup_tok_ep(setup_tok_ep),
    .setup_wr_done(setup_wr_done), .setup_wr_ep(setup_wr_ep),
    .buf_fill(buf_fill), .buf_fill_ep(buf_fill_ep),
    .buf_drain(buf_drain), .buf_drain_ep(buf_drain_ep),
    .rd_req(rd_req), .rd_ep(rd_ep), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  // kind: 0 token, 1 setup written, 2 fill, 3 drain
  task automatic pulse(input int kind, input logic [3:0] ep);
    @(negedge clk);
    case (kind)
      0: begin setup_tok = 1'b1; setup_tok_ep = ep; end
      1: begin setup_wr_done = 1'b1; setup_wr_ep = ep; end
      2: begin buf_fill = 1'b1; buf_fill_ep = ep; end
      default: begin buf_drain = 1'b1; buf_drain_ep = ep; end
    endcase
    @(negedge clk);
    setup_tok = 1'b0; setup_wr_done = 1'b0; buf_fill = 1'b0; buf_drain = 1'b0;
  endtask

  task automatic expect_stat(input logic [3:0] ep, input logic [7:0] exp, input string req);
    @(negedge clk); rd_req = 1'b1; rd_ep = ep;
    @(negedge clk); rd_req = 1'b0;
    check({req, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
    check(req, rd_data, exp);
  endtask

  task automatic t_reset;
    expect_stat(4'd0, 8'h00, "R1 ep0");
    expect_stat(4'd5, 8'h00, "R1 ep5");
    expect_stat(4'd15, 8'h00, "R1 ep15");
  endtask

  task automatic t_read_timing;
    @(negedge clk);
    check("R2 idle valid", {7'd0, rd_valid}, 8'h00);
    rd_req = 1'b1; rd_ep = 4'd9;
    @(negedge clk); rd_req = 1'b0;
    check("R2 valid after req", {7'd0, rd_valid}, 8'h01);
    @(negedge clk);
    check("R2 valid one cycle", {7'd0, rd_valid}, 8'h00);
  endtask

  task automatic t_stall_unstall;
    send_cmd(8'h45);
    expect_stat(4'd5, 8'h80, "R3 stall ep5");
    send_cmd(8'h85);
    expect_stat(4'd5, 8'h00, "R4 unstall ep5");
  endtask

  task automatic t_out_flow;
    pulse(2, 4'd2);
    expect_stat(4'd2, 8'h30, "R9 R10 first fill OUT");
    pulse(2, 4'd2);
    expect_stat(4'd2, 8'h60, "R9 R10 second fill OUT");
    pulse(2, 4'd2);
    expect_stat(4'd2, 8'h60, "R9 fill into full ignored");
    pulse(3, 4'd2);
    expect_stat(4'd2, 8'h42, "R9 drain moves cpu select");
    send_cmd(8'h42);
    expect_stat(4'd2, 8'hC2, "R3 stall keeps flags");
    pulse(2, 4'd2);
    pulse(3, 4'd2);
    expect_stat(4'd2, 8'hC2, "R11 stalled ignores traffic");
    send_cmd(8'h82);
    expect_stat(4'd2, 8'h00, "R4 unstall reinit");
    pulse(3, 4'd2);
    expect_stat(4'd2, 8'h00, "R9 drain of empty ignored");
  endtask

  task automatic t_in_flow;
    pulse(2, 4'd3);
    expect_stat(4'd3, 8'h22, "R9 R10 IN fill no toggle");
    pulse(3, 4'd3);
    expect_stat(4'd3, 8'h12, "R10 IN drain toggles");
    send_cmd(8'h83);
    expect_stat(4'd3, 8'h00, "R4 unstall of unstalled reinit");
  endtask

  task automatic t_ignored;
    pulse(2, 4'd6);
    expect_stat(4'd6, 8'h30, "R5 setup ep6");
    send_cmd(8'h36);
    send_cmd(8'h56);
    send_cmd(8'h96);
    send_cmd(8'hC6);
    send_cmd(8'h06);
    send_cmd(8'h76);
    expect_stat(4'd6, 8'h30, "R5 bad codes ignored");
  endtask

  task automatic t_setup_unstall;
    pulse(2, 4'd0);
    expect_stat(4'd0, 8'h30, "R10 ep0 fill");
    send_cmd(8'h40);
    expect_stat(4'd0, 8'hB0, "R3 ep0 stalled");
    pulse(0, 4'd0);
    expect_stat(4'd0, 8'h00, "R6 token unstalls reinit");
    pulse(1, 4'd0);
    expect_stat(4'd0, 8'h04, "R7 setup held");
  endtask

  task automatic t_restall;
    send_cmd(8'h41);
    expect_stat(4'd1, 8'h80, "R6 ep1 stalled");
    @(negedge clk);
    setup_tok = 1'b1; setup_tok_ep = 4'd1; cmd_valid = 1'b1; cmd_code = 8'h41;
    @(negedge clk);
    setup_tok = 1'b0; cmd_valid = 1'b0;
    expect_stat(4'd1, 8'h80, "R6 restall same cycle wins");
    pulse(1, 4'd1);
    expect_stat(4'd1, 8'h84, "R7 ep1 setup held");
    pulse(0, 4'd4);
    pulse(1, 4'd4);
    expect_stat(4'd4, 8'h00, "R6 setup on general ep ignored");
  endtask

  task automatic t_overwrite;
    pulse(0, 4'd0);
    expect_stat(4'd0, 8'h08, "R7 overwrite set");
    expect_stat(4'd0, 8'h08, "R8 kept while writing");
    pulse(1, 4'd0);
    expect_stat(4'd0, 8'h0C, "R8 read shows overwrite");
    expect_stat(4'd0, 8'h04, "R8 cleared after read");
    pulse(3, 4'd0);
    expect_stat(4'd0, 8'h00, "R7 drain clears held");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog all R: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_timing();
    t_stall_unstall();
    t_out_flow();
    t_in_flow();
    t_ignored();
    t_setup_unstall();
    t_restall();
    t_overwrite();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule